// File: doc/BRIEF.md
# Safety-Gated Command Executor

This block carries out control commands that a header interpreter has already decoded. Each request carries an opcode, a link index and a signal mask. The block drives a level-held processor reset line and a bank of general-purpose external signal lines toward a processor command interface. It also pulses a per-link reset vector, either for one chosen link or for every link at once.

Commands that can disturb the system are safety-critical. These are holding the processor in reset and any link reset. Such a command runs only after a separate arming request. The arm is used up by exactly one executed critical command. A critical command that arrives while the block is disarmed is refused, and a refusal strobe is raised so that an error path can report it.

Top module: `cmd_executor`

## Requirements
- R1: After system reset, every output is low: processor reset released, all external signals off, no link reset, no acknowledge, no refusal. The arm is clear.
- R2: The block accepts one request per clock. `reqAck` is high in exactly the cycle after each cycle with `reqValid` high, and it is low otherwise.
- R3: Opcode 0 (arm) sets the arming register. It changes no output except `reqAck`, and a repeated arm keeps the block armed.
- R4: Three opcodes are critical: 1 (hold the processor in reset), 5 (reset one link) and 6 (reset all links). A critical request that arrives while armed executes and clears the arm, so a second critical request with no new arm is refused.
- R5: A critical request while disarmed changes no output. `reqRejected` is high in the cycle after it.
- R6: Opcode 2 drives `cpuReset` low without any arm and leaves the arm unchanged.
- R7: Opcode 3 sets the `extSig` bits that are set in `reqSig`. Opcode 4 clears them. Other bits are kept, no arm is needed, and the arm is unchanged.
- R8: Opcode 5 with index `reqLink` below NUM_LINKS drives only bit `reqLink` of `linkReset` high for exactly one cycle, starting the cycle after the request.
- R9: Opcode 6 drives every bit of `linkReset` high for exactly one cycle, starting the cycle after the request.
- R10: Opcode 5 with `reqLink` at or above NUM_LINKS is refused. It has no effect and does not consume the arm.
- R11: Opcode 7 is undefined. It is refused, has no effect and does not consume the arm.
- R12: `cpuReset` and `extSig` keep their values through idle cycles and through requests that do not target them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous system reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 3 | Command opcode |
| reqLink | input | LINK_IDX_W | Link index for a single-link reset |
| reqSig | input | NUM_SIG | Mask for external signal set or clear |
| reqAck | output | 1 | Request acknowledged (cycle after request) |
| reqRejected | output | 1 | Request refused (disarmed, bad index or undefined opcode) |
| cpuReset | output | 1 | Level-held processor reset |
| extSig | output | NUM_SIG | Level-held external signals |
| linkReset | output | NUM_LINKS | One-cycle reset pulses, one bit per link |

## Verification
The assertions check several rules on every cycle. Each request is acknowledged one cycle later and no acknowledge appears without a request. A refused critical command raises the refusal strobe, and an executed critical command leaves the block disarmed. A single-link reset gives a one-hot pulse, and the reset vector returns to zero when no reset is strobed. The level outputs hold steady unless their strobes fire. Other behaviour shows only in the bench's scenarios, where a reference model compares every output each clock: the arm surviving non-critical, out-of-range and undefined requests, the exact bit patterns of the signal mask, and the order of arm, execute and refuse across back-to-back requests.

// File: rtl/cmd_exec_pkg.sv
package cmd_exec_pkg;

  typedef enum logic [2:0] {
    OP_ARM      = 3'd0,
    OP_CPU_HOLD = 3'd1,
    OP_CPU_FREE = 3'd2,
    OP_SIG_ON   = 3'd3,
    OP_SIG_OFF  = 3'd4,
    OP_LINK_ONE = 3'd5,
    OP_LINK_ALL = 3'd6,
    OP_SPARE    = 3'd7
  } cmdOp_t;

  // Strobes from control to datapath, one cycle wide each.
  typedef struct packed {
    logic cpuSet;
    logic cpuClr;
    logic sigSet;
    logic sigClr;
    logic linkOne;
    logic linkAll;
  } execStrobe_t;

endpackage

// File: rtl/cmd_exec_ctrl.sv
module cmd_exec_ctrl
  import cmd_exec_pkg::*;
#(
  parameter int NUM_LINKS  = 3,
  parameter int LINK_IDX_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [2:0]            reqOp,
  input  logic [LINK_IDX_W-1:0] reqLink,
  output execStrobe_t           strobe,
  output logic                  reqAck,
  output logic                  reqRejected
);

  localparam logic [LINK_IDX_W:0] LINK_LIMIT = (LINK_IDX_W+1)'(NUM_LINKS);

  cmdOp_t op;
  logic   armed;
  logic   linkInRange;
  logic   critical;
  logic   malformed;
  logic   refuse;
  logic   go;

  assign op          = cmdOp_t'(reqOp);
  assign linkInRange = ({1'b0, reqLink} < LINK_LIMIT);
  assign critical    = (op == OP_CPU_HOLD) || (op == OP_LINK_ONE) || (op == OP_LINK_ALL);
  assign malformed   = (op == OP_SPARE) || ((op == OP_LINK_ONE) && !linkInRange);
  assign refuse      = reqValid && (malformed || (critical && !armed));
  assign go          = reqValid && !refuse;

  always_comb begin
    strobe         = '0;
    strobe.cpuSet  = go && (op == OP_CPU_HOLD);
    strobe.cpuClr  = go && (op == OP_CPU_FREE);
    strobe.sigSet  = go && (op == OP_SIG_ON);
    strobe.sigClr  = go && (op == OP_SIG_OFF);
    strobe.linkOne = go && (op == OP_LINK_ONE);
    strobe.linkAll = go && (op == OP_LINK_ALL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed       <= 1'b0;
      reqAck      <= 1'b0;
      reqRejected <= 1'b0;
    end else begin
      reqAck      <= reqValid;
      reqRejected <= refuse;
      if (go && op == OP_ARM)  armed <= 1'b1;
      else if (go && critical) armed <= 1'b0;
    end
  end

  // R2: acknowledge follows each request by one cycle
  p_ack_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> reqAck);
  // R2: no acknowledge without a request
  p_no_stray_ack_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !reqAck);
  // R4: an executed critical command leaves the next critical one refused
  p_arm_consumed_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cpuSet || strobe.linkOne || strobe.linkAll) ##1 (reqValid && critical)
    |=> reqRejected);
  // R5: a disarmed critical request is refused
  p_disarmed_refused_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && critical && !armed) |=> reqRejected);

endmodule

// File: rtl/cmd_exec_dpath.sv
module cmd_exec_dpath
  import cmd_exec_pkg::*;
#(
  parameter int NUM_LINKS  = 3,
  parameter int LINK_IDX_W = 2,
  parameter int NUM_SIG    = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  execStrobe_t           strobe,
  input  logic [LINK_IDX_W-1:0] reqLink,
  input  logic [NUM_SIG-1:0]    reqSig,
  output logic                  cpuReset,
  output logic [NUM_SIG-1:0]    extSig,
  output logic [NUM_LINKS-1:0]  linkReset
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuReset <= 1'b0;
      extSig   <= '0;
    end else begin
      if (strobe.cpuSet)      cpuReset <= 1'b1;
      else if (strobe.cpuClr) cpuReset <= 1'b0;
      if (strobe.sigSet)      extSig <= extSig | reqSig;
      else if (strobe.sigClr) extSig <= extSig & ~reqSig;
    end
  end

  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
    always_ff @(posedge clk) begin
      if (!rstN) linkReset[g] <= 1'b0;
      else       linkReset[g] <= strobe.linkAll ||
                                 (strobe.linkOne && (reqLink == LINK_IDX_W'(g)));
    end
  end

  // R8: a single-link strobe gives a one-hot pulse
  p_single_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.linkOne |=> $onehot(linkReset));
  // R8: the pulse lasts one cycle unless re-strobed
  p_pulse_ends_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.linkOne || strobe.linkAll) |=> (linkReset == '0));
  // R12: processor reset holds without its strobes
  p_cpu_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.cpuSet || strobe.cpuClr) |=> $stable(cpuReset));
  // R12: external signals hold without their strobes
  p_sig_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.sigSet || strobe.sigClr) |=> $stable(extSig));

endmodule

// File: rtl/cmd_executor.sv
module cmd_executor
  import cmd_exec_pkg::*;
#(
  parameter int NUM_LINKS  = 3,
  parameter int NUM_SIG    = 4,
  parameter int LINK_IDX_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [2:0]            reqOp,
  input  logic [LINK_IDX_W-1:0] reqLink,
  input  logic [NUM_SIG-1:0]    reqSig,
  output logic                  reqAck,
  output logic                  reqRejected,
  output logic                  cpuReset,
  output logic [NUM_SIG-1:0]    extSig,
  output logic [NUM_LINKS-1:0]  linkReset
);

  execStrobe_t strobe;

  cmd_exec_ctrl #(.NUM_LINKS(NUM_LINKS), .LINK_IDX_W(LINK_IDX_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqLink(reqLink), .strobe(strobe), .reqAck(reqAck),
    .reqRejected(reqRejected)
  );

  cmd_exec_dpath #(.NUM_LINKS(NUM_LINKS), .LINK_IDX_W(LINK_IDX_W),
                   .NUM_SIG(NUM_SIG)) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqLink(reqLink),
    .reqSig(reqSig), .cpuReset(cpuReset), .extSig(extSig),
    .linkReset(linkReset)
  );

endmodule

// File: tb/test_cmd_executor.sv
module test_cmd_executor;

  localparam int NL = 3;
  localparam int NS = 4;
  localparam int LW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [2:0]    reqOp = '0;
  logic [LW-1:0] reqLink = '0;
  logic [NS-1:0] reqSig = '0;
  logic          reqAck, reqRejected, cpuReset;
  logic [NS-1:0] extSig;
  logic [NL-1:0] linkReset;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  bit            mArmed = 0;
  bit            mCpu = 0;
  logic [NS-1:0] mSig = '0;
  logic [NL-1:0] mLink = '0;
  bit            mAck = 0;
  bit            mRej = 0;

  always #2.5 clk = ~clk;

  cmd_executor #(.NUM_LINKS(NL), .NUM_SIG(NS)) i_cmd_executor (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqLink(reqLink), .reqSig(reqSig), .reqAck(reqAck),
    .reqRejected(reqRejected), .cpuReset(cpuReset), .extSig(extSig),
    .linkReset(linkReset)
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compareAll(string req);
    chk(req, "reqAck", int'(reqAck), int'(mAck));
    chk(req, "reqRejected", int'(reqRejected), int'(mRej));
    chk(req, "cpuReset", int'(cpuReset), int'(mCpu));
    chk(req, "extSig", int'(extSig), int'(mSig));
    chk(req, "linkReset", int'(linkReset), int'(mLink));
  endtask

  task automatic model(bit v, int op, int lnk, logic [NS-1:0] sig);
    mAck = v; mRej = 0; mLink = '0;
    if (v) begin
      case (op)
        0: mArmed = 1;
        1: if (mArmed) begin mCpu = 1; mArmed = 0; end else mRej = 1;
        2: mCpu = 0;
        3: mSig = mSig | sig;
        4: mSig = mSig & ~sig;
        5: if (lnk >= NL || !mArmed) mRej = 1;
           else begin mLink = '0; mLink[lnk] = 1'b1; mArmed = 0; end
        6: if (mArmed) begin mLink = '1; mArmed = 0; end else mRej = 1;
        default: mRej = 1;
      endcase
    end
  endtask

  task automatic step(string req, bit v, int op, int lnk, logic [NS-1:0] sig);
    @(negedge clk);
    reqValid = v; reqOp = 3'(op); reqLink = LW'(lnk); reqSig = sig;
    @(posedge clk);
    model(v, op, lnk, sig);
    #1;
    compareAll(req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compareAll("R1");
    @(negedge clk); rstN = 1'b1;
    step("R1", 0, 0, 0, 4'h0);
    step("R5", 1, 1, 0, 4'h0);     // hold cpu while disarmed
    step("R5", 1, 6, 0, 4'h0);     // all-link while disarmed
    step("R3", 1, 0, 0, 4'h0);     // arm
    step("R3", 1, 0, 0, 4'h0);     // arm again
    step("R4", 1, 1, 0, 4'h0);     // hold cpu, armed
    step("R4", 1, 1, 0, 4'h0);     // refused, arm used up
    step("R12", 0, 0, 0, 4'h0);
    step("R12", 0, 0, 0, 4'h0);
    step("R6", 1, 2, 0, 4'h0);     // release cpu
    step("R7", 1, 3, 0, 4'h5);
    step("R7", 1, 3, 0, 4'h2);
    step("R7", 1, 4, 0, 4'h4);
    step("R12", 1, 2, 0, 4'h0);
    step("R3", 1, 0, 0, 4'h0);
    step("R7", 1, 3, 0, 4'h8);     // arm kept through signal change
    step("R6", 1, 2, 0, 4'h0);     // arm kept through release
    step("R8", 1, 5, 1, 4'h0);
    step("R8", 0, 0, 0, 4'h0);     // pulse ended
    step("R3", 1, 0, 0, 4'h0);
    step("R10", 1, 5, 3, 4'h0);    // out of range
    step("R10", 1, 5, 2, 4'h0);    // arm still there
    step("R5", 1, 5, 0, 4'h0);     // disarmed again
    step("R3", 1, 0, 0, 4'h0);
    step("R11", 1, 7, 0, 4'hF);    // undefined opcode
    step("R9", 1, 6, 0, 4'h0);
    step("R9", 0, 0, 0, 4'h0);
    step("R3", 1, 0, 0, 4'h0);
    step("R8", 1, 5, 0, 4'h0);
    step("R2", 1, 0, 0, 4'h0);
    step("R2", 1, 6, 0, 4'h0);
    step("R2", 1, 4, 0, 4'hF);
    step("R12", 0, 0, 0, 4'h0);
    step("R12", 0, 0, 0, 4'h0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule